// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst access to a synchronous memory. A burst begins when either of two active-low address strobes is low at a rising clock edge: one is driven by the processor and one by a cache controller. On that edge the block captures the external address as the start of the burst and clears its internal beat count.

After the load, each rising edge with the active-low advance input low steps the beat count by one. An edge with advance high holds the address, which gives the requester its wait states. The two low address bits follow the beat count in one of two orders, chosen by a static mode input. Linear order (mode low) adds the count to the start bits and wraps within the aligned group of four. Interleaved order (mode high) XORs the count into the start bits. The upper address bits always come from the captured start address.

The output is derived from registered state, so it settles right after the edge that caused the change. The mode input is configuration and is expected to stay fixed while a burst is running.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, addr_o is all zeros.
- R2: When strb_cpu_ni is low at a rising edge, addr_o equals the addr_i sampled at that edge (beat zero) from that edge until the next change.
- R3: When strb_ctl_ni is low at a rising edge, the address is loaded exactly as in R2, whatever the state of strb_cpu_ni.
- R4: At an edge where both strobes are high and adv_ni is high, addr_o keeps its value.
- R5: With mode_i = 0 (linear), addr_o[1:0] equals (start[1:0] + beats) mod 4, where beats is the number of advance edges since the last load.
- R6: With mode_i = 1 (interleaved), addr_o[1:0] equals start[1:0] XOR beats (mod 4).
- R7: At edges without a strobe, addr_o[ADDR_W-1:2] does not change; it stays equal to the upper bits of the loaded start address.
- R8: Four advances after a load, addr_o returns to the start address, and stepping continues around the same aligned group of four.
- R9: When a strobe and adv_ni are both low at the same edge, the load wins: addr_o becomes addr_i at beat zero.
- R10: A load in the middle of a burst clears the beat count, so the next advance produces the second beat of the new burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External start address |
| strb_cpu_ni | input | 1 | Processor address strobe, active low |
| strb_ctl_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst word address |

## Verification
Every result, whether a load, a step or a hold, appears on addr_o after exactly one rising edge: the edge that samples the strobes and advance. There is no further pipeline stage. The bench changes inputs just after a falling edge, lets one rising edge pass, and compares addr_o at the following falling edge against a model that it updates at that rising edge. This keeps every comparison away from the edge that changes the output. The mode input is changed only on load cycles, because it is static configuration.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } beat_op_e;
endpackage

// File: rtl/bas_start_reg.sv
module bas_start_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] start_o
);
  logic [ADDR_W-1:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     start_q <= '0;
    else if (load_i) start_q <= addr_i;
  end

  assign start_o = start_q;
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  beat_op_e          op_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] beat_q, beat_d;

  always_comb begin
    unique case (op_i)
      OP_LOAD: beat_d = '0;
      OP_STEP: beat_d = beat_q + 1'b1;  // wraps naturally at 2**BEAT_W
      default: beat_d = beat_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= '0;
    else         beat_q <= beat_d;
  end

  assign beat_o = beat_q;
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order_i,
  input  logic [BEAT_W-1:0] start_lo_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] lo_o
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;
  logic [BEAT_W:0]   carry;

  // ripple add per bit: sum stays inside the aligned group
  assign carry[0] = 1'b0;
  for (genvar b = 0; b < BEAT_W; b++) begin : g_bit
    assign lin_lo[b]  = start_lo_i[b] ^ beat_i[b] ^ carry[b];
    assign carry[b+1] = (start_lo_i[b] & beat_i[b]) |
                        (carry[b] & (start_lo_i[b] ^ beat_i[b]));
    assign ilv_lo[b]  = start_lo_i[b] ^ beat_i[b];
  end

  assign lo_o = (order_i == ORDER_INTERLEAVE) ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strb_cpu_ni,
  input  logic              strb_ctl_ni,
  input  logic              adv_ni,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              load;
  beat_op_e          op;
  logic [ADDR_W-1:0] start;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lo;
  order_e            order;

  assign load  = ~strb_cpu_ni | ~strb_ctl_ni;
  // strobe outranks advance
  assign op    = load ? OP_LOAD : (~adv_ni ? OP_STEP : OP_HOLD);
  assign order = order_e'(mode_i);

  bas_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .start_o(start)
  );

  bas_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .beat_o(beat)
  );

  bas_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i   (order),
    .start_lo_i(start[BEAT_W-1:0]),
    .beat_i    (beat),
    .lo_o      (lo)
  );

  assign addr_o = {start[ADDR_W-1 -: UP_W], lo};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              strb_cpu_ni,
  input logic              strb_ctl_ni,
  input logic              adv_ni,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic any_strb;
  assign any_strb = ~strb_cpu_ni | ~strb_ctl_ni;

  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_zero_R1: assert (addr_o == '0);
  end

  // R2 / R3: either strobe loads beat zero
  assert_load_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strb |=> addr_o == $past(addr_i));

  assert_hold_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_strb && adv_ni) |=> (!$stable(mode_i) || $stable(addr_o)));

  assert_linear_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_strb && !adv_ni && !mode_i) |=>
      (mode_i || addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)));

  assert_ilv_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_strb && !adv_ni && mode_i) |=>
      (!mode_i || $countones(addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) != 0));

  assert_upper_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_strb |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .strb_cpu_ni(strb_cpu_ni),
  .strb_ctl_ni(strb_ctl_ni),
  .adv_ni     (adv_ni),
  .mode_i     (mode_i),
  .addr_o     (addr_o)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int  AW = 16;
  localparam int  BW = 2;
  localparam time CLK_PERIOD = 10ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          strb_cpu_ni = 1'b1;
  logic          strb_ctl_ni = 1'b1;
  logic          adv_ni = 1'b1;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] m_base = '0;
  logic [BW-1:0] m_beat = '0;
  logic          done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .strb_cpu_ni(strb_cpu_ni), .strb_ctl_ni(strb_ctl_ni),
    .adv_ni(adv_ni), .mode_i(mode_i), .addr_o(addr_o)
  );

  function automatic logic [AW-1:0] exp_addr(input logic md);
    logic [BW-1:0] lo;
    lo = md ? (m_base[BW-1:0] ^ m_beat) : BW'(m_base[BW-1:0] + m_beat);
    return {m_base[AW-1:BW], lo};
  endfunction

  task automatic check(input logic [AW-1:0] exp, input string tag);
    checks++;
    if (addr_o !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%h expected=%h", tag, addr_o, exp);
    end
  endtask

  // called just after a falling edge
  task automatic cyc(input logic [AW-1:0] a, input logic cpu_n, input logic ctl_n,
                     input logic adv_n, input logic md, input string tag);
    addr_i = a; strb_cpu_ni = cpu_n; strb_ctl_ni = ctl_n; adv_ni = adv_n; mode_i = md;
    @(posedge clk_i);
    if (!cpu_n || !ctl_n) begin m_base = a; m_beat = '0; end
    else if (!adv_n) m_beat = m_beat + 1'b1;
    @(negedge clk_i);
    check(exp_addr(md), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] seq_start;
    void'($urandom(32'd4711));
    addr_i = 16'hBEEF; strb_cpu_ni = 1'b0; adv_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check('0, "R1");
    rst_ni = 1'b1;
    strb_cpu_ni = 1'b1; adv_ni = 1'b1;
    @(negedge clk_i);
    check('0, "R1");

    // linear from low bits 2: 2,3,0,1,2,3
    cyc(16'h12A6, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
    check(16'h12A6, "R2");
    for (int i = 0; i < 3; i++) cyc('0, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    check(16'h12A5, "R5");
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    check(16'h12A6, "R8");
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    check(16'h12A7, "R7");
    for (int i = 0; i < 3; i++) cyc(16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
    check(16'h12A7, "R4");

    // controller strobe, interleaved from low bits 1: 1,0,3,2,1
    cyc(16'h7C31, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
    check(16'h7C31, "R3");
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b1, "R6"); check(16'h7C30, "R6");
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b1, "R6"); check(16'h7C33, "R6");
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b1, "R6"); check(16'h7C32, "R6");
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b1, "R8"); check(16'h7C31, "R8");

    // strobe plus advance: load wins
    cyc(16'h0403, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
    check(16'h0403, "R9");
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b0, "R5"); check(16'h0400, "R5");
    // mid-burst reload clears the beat count
    cyc(16'h5551, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b0, "R10"); check(16'h5552, "R10");
    // both strobes together
    cyc(16'h9002, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
    check(16'h9002, "R3");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] r;
      logic cpu_n, ctl_n, adv_n, md;
      string tag;
      r = 4'($urandom);
      cpu_n = (r[1:0] != 2'd0);
      ctl_n = ($urandom_range(0, 9) != 0);
      adv_n = r[2] & r[3];
      md = mode_i;
      if (!cpu_n || !ctl_n) begin
        md = 1'($urandom);
        tag = !cpu_n ? "R2" : "R3";
      end else if (adv_n) tag = "R4";
      else tag = md ? "R6" : "R5";
      seq_start = 16'($urandom);
      cyc(seq_start, cpu_n, ctl_n, adv_n, md, tag);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule